// File: doc/BRIEF.md
# Transmit Serializer with Wrap Loopback

This block turns 20-bit parallel transmit words into a gapless serial bit stream for an optical line driver. The system supplies a byte clock and captures each word on its rising edge. A serial clock running 20 times faster, and phase-locked to the byte clock, moves the captured word into a shift register and shifts it out one bit per serial cycle. In simulation the serial clock is an input, so no clock multiplier is built.

The bit sent to the line driver comes from one of two sources: the internal serialized stream or an external serial input. A wrap mode sends the serialized stream to the receive side for loopback and keeps the line quiet. A fault input sets a latch that holds the line output at 0 until a separate clear input releases it. Neither a fault nor a source change disturbs the serializer's own timing.

Top module: `ser_tx_wrap`

## Requirements
- R1: While `rst_n` is low, the serialized bit is 0 and the fault latch is clear. With `wrap_en` high and `src_ext` low, both `line_out` and `wrap_out` read 0.
- R2: The word on `tx_word` is captured on each rising edge of `byte_clk`. The captured word is the one loaded at the next load edge of `ser_clk`.
- R3: The first `ser_clk` rising edge after reset release loads a word, and so does every 20th edge after it, with no idle cycle between words. The first word after reset is all zeros, even if `byte_clk` pulsed during reset.
- R4: Bits leave least significant bit first. After the load edge the serialized bit is bit 0 of the word, and after the i-th following edge it is bit i.
- R5: With no fault latched and `wrap_en` low, `line_out` follows `ext_ser_in` when `src_ext` is 1 and follows the serialized bit when `src_ext` is 0.
- R6: `wrap_out` carries the serialized bit while `wrap_en` is 1, whatever `src_ext` is, and is 0 while `wrap_en` is 0.
- R7: While `wrap_en` is 1, `line_out` is 0.
- R8: A `ser_clk` rising edge that samples `fault_in` at 1 sets the fault latch. While the latch is set, `line_out` is 0 for any `src_ext` or `ext_ser_in`. `fault_in` wins over `fault_clr` on the same edge.
- R9: The fault latch stays set after `fault_in` returns to 0. It clears only on an edge that samples `fault_clr` at 1 and `fault_in` at 0.
- R10: The serializer keeps running while a fault is latched, so `wrap_out` still carries the correct serialized bit in wrap mode.
- R11: A `fault_clr` pulse while no fault is latched does not change `line_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Serial bit clock, 20 times the byte clock rate |
| byte_clk | input | 1 | System transmit byte clock; its rising edge captures the word |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| tx_word | input | WORD_W | Parallel transmit word |
| ext_ser_in | input | 1 | External serial source for the line |
| src_ext | input | 1 | 1 selects `ext_ser_in` for the line, 0 selects the serialized bit |
| wrap_en | input | 1 | Loopback mode: serialized bit goes to `wrap_out`, line held at 0 |
| fault_in | input | 1 | Fault indication; sets the fault latch |
| fault_clr | input | 1 | Clears the fault latch when `fault_in` is low |
| line_out | output | 1 | Bit to the line driver |
| wrap_out | output | 1 | Serialized bit routed to the receive path in wrap mode |

## Verification
The assertions assume that `byte_clk` is phase-locked to `ser_clk` and rises between two `ser_clk` rising edges. They also assume that each capture comes at least one serial cycle before the load edge that uses it, and that `tx_word` is stable around that rising edge. The stimulus meets these assumptions by deriving `byte_clk` from a count of serial edges. It raises `byte_clk` on a serial falling edge ten cycles before each load, changes `tx_word` five cycles before that rise, and changes every other input only on falling edges.

// File: rtl/txs_pkg.sv
`timescale 1ns/1ps
package txs_pkg;

  typedef enum logic [1:0] {
    SRC_SER  = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_WRAP = 2'd2,
    SRC_OFF  = 2'd3
  } line_src_e;

  // Priority: latched fault, then wrap mode, then the source select.
  function automatic line_src_e pick_src(input logic flt, input logic wrap,
                                         input logic use_ext);
    if (flt)          return SRC_OFF;
    else if (wrap)    return SRC_WRAP;
    else if (use_ext) return SRC_EXT;
    else              return SRC_SER;
  endfunction

  // Bit index after the current one, wrapping at the word end.
  function automatic int unsigned step_idx(input int unsigned idx,
                                           input int unsigned width);
    return (idx == width - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/txs_capture.sv
`timescale 1ns/1ps
module txs_capture #(
  parameter int WORD_W = 20
) (
  input  logic              byte_clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] hold_q
);

  always_ff @(posedge byte_clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= word_in;
  end

endmodule

// File: rtl/txs_shifter.sv
`timescale 1ns/1ps
module txs_shifter #(
  parameter int WORD_W = 20
) (
  input  logic              ser_clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] hold_word,
  output logic              ser_bit,
  output logic              load_evt
);

  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  logic [WORD_W-1:0] sreg;
  logic [IDX_W-1:0]  idx;

  assign load_evt = (idx == LAST_IDX);
  assign ser_bit  = sreg[0];

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      idx  <= LAST_IDX;
    end else begin
      idx <= IDX_W'(txs_pkg::step_idx(32'(idx), WORD_W));
      if (load_evt) sreg <= hold_word;
      else          sreg <= {1'b0, sreg[WORD_W-1:1]};
    end
  end

  // Checker state: cycles since the previous load edge.
  logic [IDX_W:0] gap_cnt;
  logic           seen_load;
  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt   <= '0;
      seen_load <= 1'b0;
    end else if (load_evt) begin
      gap_cnt   <= '0;
      seen_load <= 1'b1;
    end else begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // R4: the load edge puts bit 0 of the captured word on the line.
  assert_lsb_first_R4: assert property (@(posedge ser_clk) disable iff (!rst_n)
    load_evt |=> (ser_bit == $past(hold_word[0])));

  // R3: loads are exactly WORD_W cycles apart, no gap.
  assert_gapless_R3: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (load_evt && seen_load) |-> (gap_cnt == (IDX_W+1)'(WORD_W - 1)));

  // R3: no two loads closer than a word.
  assert_no_early_load_R3: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (seen_load && gap_cnt < (IDX_W+1)'(WORD_W - 1)) |-> !load_evt);

endmodule

// File: rtl/txs_fault_latch.sv
`timescale 1ns/1ps
module txs_fault_latch (
  input  logic ser_clk,
  input  logic rst_n,
  input  logic fault_in,
  input  logic fault_clr,
  output logic fault_q
);

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n)         fault_q <= 1'b0;
    else if (fault_in)  fault_q <= 1'b1;
    else if (fault_clr) fault_q <= 1'b0;
  end

  // R8: a sampled fault always sets the latch, clear or not.
  assert_fault_sets_R8: assert property (@(posedge ser_clk) disable iff (!rst_n)
    fault_in |=> fault_q);

  // R9: without a clear the latch holds.
  assert_fault_holds_R9: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (fault_q && !fault_clr) |=> fault_q);

  // R11: no fault input, no latch, stays clear.
  assert_no_spurious_R11: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (!fault_q && !fault_in) |=> !fault_q);

endmodule

// File: rtl/ser_tx_wrap.sv
`timescale 1ns/1ps
module ser_tx_wrap #(
  parameter int WORD_W = 20
) (
  input  logic              ser_clk,
  input  logic              byte_clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              ext_ser_in,
  input  logic              src_ext,
  input  logic              wrap_en,
  input  logic              fault_in,
  input  logic              fault_clr,
  output logic              line_out,
  output logic              wrap_out
);

  import txs_pkg::*;

  logic [WORD_W-1:0] hold_word;
  logic              ser_bit;
  logic              load_evt;
  logic              fault_q;
  line_src_e         line_src;

  txs_capture #(.WORD_W(WORD_W)) u_capture (
    .byte_clk (byte_clk),
    .rst_n    (rst_n),
    .word_in  (tx_word),
    .hold_q   (hold_word)
  );

  txs_shifter #(.WORD_W(WORD_W)) u_shifter (
    .ser_clk   (ser_clk),
    .rst_n     (rst_n),
    .hold_word (hold_word),
    .ser_bit   (ser_bit),
    .load_evt  (load_evt)
  );

  txs_fault_latch u_fault (
    .ser_clk   (ser_clk),
    .rst_n     (rst_n),
    .fault_in  (fault_in),
    .fault_clr (fault_clr),
    .fault_q   (fault_q)
  );

  assign line_src = pick_src(fault_q, wrap_en, src_ext);

  always_comb begin
    case (line_src)
      SRC_SER: line_out = ser_bit;
      SRC_EXT: line_out = ext_ser_in;
      default: line_out = 1'b0;
    endcase
  end

  assign wrap_out = wrap_en & ser_bit;

  // R8: latched fault silences the line.
  assert_fault_off_R8: assert property (@(posedge ser_clk) disable iff (!rst_n)
    fault_q |-> !line_out);

  // R7: wrap mode keeps loopback data off the line.
  assert_wrap_quiet_R7: assert property (@(posedge ser_clk) disable iff (!rst_n)
    wrap_en |-> !line_out);

  // R5: external source reaches the line when nothing overrides it.
  assert_ext_pass_R5: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (!fault_q && !wrap_en && src_ext) |-> (line_out == ext_ser_in));

  // R6: receive-side loopback mirrors the serializer, even under a fault (R10).
  assert_wrap_path_R6: assert property (@(posedge ser_clk) disable iff (!rst_n)
    wrap_en |-> (wrap_out == ser_bit));

  assert_wrap_idle_R6: assert property (@(posedge ser_clk) disable iff (!rst_n)
    !wrap_en |-> !wrap_out);

endmodule

// File: tb/ser_tx_wrap_bench.sv
`timescale 1ns/1ps
module ser_tx_wrap_bench;

  localparam int W     = 20;
  localparam int CYCLES = 1000;

  logic         ser_clk = 1'b0;
  logic         byte_clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] tx_word = '0;
  logic         ext_ser_in = 1'b0;
  logic         src_ext = 1'b0;
  logic         wrap_en = 1'b0;
  logic         fault_in = 1'b0;
  logic         fault_clr = 1'b0;
  logic         line_out;
  logic         wrap_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 ser_clk = ~ser_clk;

  ser_tx_wrap #(.WORD_W(W)) u_ser_tx_wrap (
    .ser_clk    (ser_clk),
    .byte_clk   (byte_clk),
    .rst_n      (rst_n),
    .tx_word    (tx_word),
    .ext_ser_in (ext_ser_in),
    .src_ext    (src_ext),
    .wrap_en    (wrap_en),
    .fault_in   (fault_in),
    .fault_clr  (fault_clr),
    .line_out   (line_out),
    .wrap_out   (wrap_out)
  );

  // Word k sent after reset; word 0 is the all-zero reset word (R3).
  function automatic logic [W-1:0] word_of(input int k);
    logic [W-1:0] one_hot;
    one_hot = W'(1) << (k % W);
    if (k == 0)          return '0;
    else if (k % 4 == 1) return one_hot;
    else if (k % 4 == 2) return ~one_hot;
    else if (k % 8 == 3) return '1;
    else                 return W'(k * 32'h3A7C5 + 17);
  endfunction

  task automatic check(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0b expected=%0b at t=%0t", tag, got, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit           flt;
    int           k;
    int           b;
    logic         exp_bit;
    logic         exp_line;
    string        tag;

    // R1: reset state, wrap on, source serial; byte clock pulsed in reset.
    wrap_en = 1'b1;
    tx_word = 20'hABCDE;
    repeat (2) @(negedge ser_clk);
    byte_clk = 1'b1;
    repeat (2) @(negedge ser_clk);
    byte_clk = 1'b0;
    check("R1 line in reset", line_out, 1'b0);
    check("R1 wrap in reset", wrap_out, 1'b0);
    wrap_en = 1'b0;
    tx_word = '0;
    @(negedge ser_clk);
    rst_n = 1'b1;

    flt = 1'b0;
    for (int p = 1; p <= CYCLES; p++) begin
      @(negedge ser_clk);
      // Inputs held across the edge just taken: update the fault model.
      if (fault_in)       flt = 1'b1;
      else if (fault_clr) flt = 1'b0;

      k = (p - 1) / W;
      b = (p - 1) % W;
      exp_bit = word_of(k)[b];

      if (flt)          exp_line = 1'b0;
      else if (wrap_en) exp_line = 1'b0;
      else if (src_ext) exp_line = ext_ser_in;
      else              exp_line = exp_bit;

      if (flt)                        tag = "R8 R9 latched fault";
      else if (p >= 951 && p <= 960)  tag = "R11 clear without fault";
      else if (wrap_en)               tag = "R7 wrap quiet";
      else if (src_ext)               tag = "R5 external source";
      else if (k == 0)                tag = "R3 first word zero";
      else                            tag = "R2 R4 serial bit";
      check(tag, line_out, exp_line);

      if (wrap_en)
        check(flt ? "R10 wrap under fault" : "R6 wrap path", wrap_out, exp_bit);
      else
        check("R6 wrap idle", wrap_out, 1'b0);

      // Byte-clock schedule: word for load 20k+1 set at 5, captured at 10.
      if (p % W == 5)  tx_word = word_of(p / W + 1);
      if (p % W == 10) byte_clk = 1'b1;
      if (p % W == 0)  byte_clk = 1'b0;

      // Inputs for the next serial period.
      begin
        int q;
        q = p + 1;
        wrap_en    = (q > 600 && q <= 800);
        if (q <= 400)      src_ext = 1'b0;
        else if (q <= 600) src_ext = ((q * 7) % 3 == 0);
        else if (q <= 800) src_ext = q[0];
        else               src_ext = (q % 3 == 0);
        ext_ser_in = (q > 800) ? 1'b1 : ((q * 13) % 5 < 2);
        fault_in   = (q == 820 || q == 850 || q == 870);
        fault_clr  = (q == 850 || q == 900 || q == 950);
        if (q > 860 && q <= 890) wrap_en = 1'b1;
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule